// File: doc/BRIEF.md
# Latched Seven-Segment Readout for a 3½-Digit Meter

This block sits at the end of a counting converter. It turns the finished reading into segment-on signals for a 3½-digit display. At the end of each conversion the converter pulses a strobe. On that clock edge the block captures three BCD digits (units, tens, hundreds), a thousands code, a sign flag and an overrange flag. It decodes them and holds the resulting segment pattern until the next strobe.

The thousands position can show only blank or a 1, so it needs a single output that lights both of its segments. An overrange reading keeps that leading 1 and blanks the three low digits. A lamp-test input lights every segment at once for display checking. While it is held, the display reads 1888 with the minus sign on.

Top module: `bcd_seg_display`

## Requirements
- R1: While reset is held and lamp test is low, all 23 segment outputs are 0.
- R2: Each full digit maps codes 0–9 to the usual seven-segment shapes, with segment a on bit 0 through segment g on bit 6, all active-high. The patterns in hex are 0:3F, 1:06, 2:5B, 3:4F, 4:66, 5:6D, 6:7D, 7:07, 8:7F, 9:6F.
- R3: A code from 10 to 15 on a full digit blanks that digit (all seven bits 0).
- R4: The thousands output is on exactly when the captured thousands code equals 1. Every other code leaves it off.
- R5: The minus output equals the captured sign flag (1 means negative). This holds even when every digit is zero.
- R6: When the captured overrange flag is 1, the three full digits are blank and the thousands output is on, whatever the digit codes are. The minus output still follows the sign.
- R7: Inputs are captured on a rising clock edge where the strobe is high and appear on the outputs right after that edge. Without a strobe, the outputs keep their values whatever the data inputs do.
- R8: While lamp test is 1, all 23 outputs are 1 at once, without waiting for a clock. This overrides overrange and the captured data. When lamp test is released, the captured pattern returns unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strobe | input | 1 | Capture pulse at the end of a conversion |
| bcd_units | input | 4 | Units BCD code |
| bcd_tens | input | 4 | Tens BCD code |
| bcd_hund | input | 4 | Hundreds BCD code |
| bcd_thou | input | 4 | Thousands code (1 lights the half digit) |
| neg | input | 1 | Sign flag, 1 = negative |
| over_range | input | 1 | Overrange flag |
| lamp_test | input | 1 | Forces every segment on |
| seg_units | output | 7 | Units segments, a = bit 0 |
| seg_tens | output | 7 | Tens segments, a = bit 0 |
| seg_hund | output | 7 | Hundreds segments, a = bit 0 |
| seg_thou | output | 1 | Both thousands segments |
| seg_minus | output | 1 | Minus sign |

## Verification
The hardest state to reach is one where the inputs and the shown pattern disagree. In that state, lamp test is pulled away or the data inputs move without a strobe. Only then can a design that leaks live inputs be told apart from one that holds. The stimulus loads an overrange reading and then changes every data input with no strobe. Next it raises and drops lamp test while the inputs still differ from the captured values. A behavioural model of the captured reading is compared with the outputs on every clock.

// File: rtl/bcd_seg_display.sv
module bcd_seg_display (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       strobe,
  input  logic [3:0] bcd_units,
  input  logic [3:0] bcd_tens,
  input  logic [3:0] bcd_hund,
  input  logic [3:0] bcd_thou,
  input  logic       neg,
  input  logic       over_range,
  input  logic       lamp_test,
  output logic [6:0] seg_units,
  output logic [6:0] seg_tens,
  output logic [6:0] seg_hund,
  output logic       seg_thou,
  output logic       seg_minus
);
  localparam int SEG_W = 7;
  localparam int NFULL = 3;

  logic [NFULL-1:0][3:0]       code;
  logic [NFULL-1:0][SEG_W-1:0] shape, held;
  logic                        thou_q, minus_q;

  assign code = {bcd_hund, bcd_tens, bcd_units};

  for (genvar i = 0; i < NFULL; i++) begin : g_dec
    always_comb begin
      unique case (code[i])
        4'd0:    shape[i] = 7'h3F;
        4'd1:    shape[i] = 7'h06;
        4'd2:    shape[i] = 7'h5B;
        4'd3:    shape[i] = 7'h4F;
        4'd4:    shape[i] = 7'h66;
        4'd5:    shape[i] = 7'h6D;
        4'd6:    shape[i] = 7'h7D;
        4'd7:    shape[i] = 7'h07;
        4'd8:    shape[i] = 7'h7F;
        4'd9:    shape[i] = 7'h6F;
        default: shape[i] = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held    <= '0;
      thou_q  <= 1'b0;
      minus_q <= 1'b0;
    end else if (strobe) begin
      held    <= over_range ? '0 : shape;
      thou_q  <= over_range || (bcd_thou == 4'd1);
      minus_q <= neg;
    end
  end

  assign seg_units = lamp_test ? '1 : held[0];
  assign seg_tens  = lamp_test ? '1 : held[1];
  assign seg_hund  = lamp_test ? '1 : held[2];
  assign seg_thou  = lamp_test | thou_q;
  assign seg_minus = lamp_test | minus_q;

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |=> (held == $past(held)) && (thou_q == $past(thou_q)) && (minus_q == $past(minus_q)));

  p_sign_r5: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> lamp_test || (seg_minus == $past(neg)));

  p_ovr_blank_r6: assert property (@(posedge clk) disable iff (!rst_n)
    strobe && over_range |=> lamp_test || (seg_thou && seg_units == 7'd0 && seg_tens == 7'd0 && seg_hund == 7'd0));

  p_bad_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
    strobe && !over_range && bcd_units > 4'd9 |=> lamp_test || seg_units == 7'd0);

  p_half_digit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    strobe && !over_range |=> lamp_test || (seg_thou == ($past(bcd_thou) == 4'd1)));
endmodule

// File: tb/tb_bcd_seg_display.sv
module tb_bcd_seg_display;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic strobe = 1'b0;
  logic [3:0] bcd_units = 4'd0, bcd_tens = 4'd0, bcd_hund = 4'd0, bcd_thou = 4'd0;
  logic neg = 1'b0, over_range = 1'b0, lamp_test = 1'b0;
  logic [6:0] seg_units, seg_tens, seg_hund;
  logic seg_thou, seg_minus;

  always #10 clk = ~clk;

  bcd_seg_display dut (.*);

  int pat [16];
  int m_u, m_t, m_h, m_th, m_s;
  int n_run = 0, n_fail = 0, cyc = 0;
  bit checking = 1'b0;
  bit done = 1'b0;
  string cur_req = "R1";

  initial begin
    for (int k = 0; k < 16; k++) pat[k] = 0;
    pat[0] = 'h3F; pat[1] = 'h06; pat[2] = 'h5B; pat[3] = 'h4F; pat[4] = 'h66;
    pat[5] = 'h6D; pat[6] = 'h7D; pat[7] = 'h07; pat[8] = 'h7F; pat[9] = 'h6F;
    m_u = 0; m_t = 0; m_h = 0; m_th = 0; m_s = 0;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      m_u <= 0; m_t <= 0; m_h <= 0; m_th <= 0; m_s <= 0;
    end else if (strobe) begin
      m_u  <= over_range ? 0 : pat[bcd_units];
      m_t  <= over_range ? 0 : pat[bcd_tens];
      m_h  <= over_range ? 0 : pat[bcd_hund];
      m_th <= (over_range || bcd_thou == 4'd1) ? 1 : 0;
      m_s  <= neg ? 1 : 0;
    end
  end

  function automatic logic [22:0] expected();
    if (lamp_test) return '1;
    return {m_s[0], m_th[0], m_h[6:0], m_t[6:0], m_u[6:0]};
  endfunction

  always begin
    @(negedge clk);
    #8;
    if (checking && !done) begin
      n_run++;
      if ({seg_minus, seg_thou, seg_hund, seg_tens, seg_units} !== expected()) begin
        n_fail++;
        $display("FAIL %s: got %h expected %h", cur_req,
                 {seg_minus, seg_thou, seg_hund, seg_tens, seg_units}, expected());
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1'b1;
      n_fail++;
      $display("FAIL watchdog: got hang expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic capture(input int u, input int t, input int h, input int th,
                         input bit s, input bit ov);
    @(negedge clk);
    bcd_units = u[3:0]; bcd_tens = t[3:0]; bcd_hund = h[3:0]; bcd_thou = th[3:0];
    neg = s; over_range = ov; strobe = 1'b1;
    @(negedge clk);
    strobe = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    cur_req = "R1";
    checking = 1'b1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    cur_req = "R2";
    for (int d = 0; d < 10; d++) capture(d, (d + 3) % 10, (d + 7) % 10, d % 2, 1'b0, 1'b0);

    cur_req = "R3";
    for (int c = 10; c < 16; c++) capture(c, 25 - c, c, 1, 1'b0, 1'b0);
    capture(4, 12, 9, 0, 1'b0, 1'b0);

    cur_req = "R4";
    capture(1, 2, 3, 0, 1'b0, 1'b0);
    capture(1, 2, 3, 1, 1'b0, 1'b0);
    capture(1, 2, 3, 2, 1'b0, 1'b0);
    capture(1, 2, 3, 15, 1'b0, 1'b0);

    cur_req = "R5";
    capture(0, 0, 0, 0, 1'b1, 1'b0);
    capture(0, 0, 0, 0, 1'b0, 1'b0);
    capture(9, 9, 9, 1, 1'b1, 1'b0);

    cur_req = "R6";
    capture(5, 3, 7, 0, 1'b1, 1'b1);
    capture(8, 8, 8, 1, 1'b0, 1'b1);
    capture(2, 11, 6, 3, 1'b1, 1'b1);

    cur_req = "R7";
    @(negedge clk);
    bcd_units = 4'd8; bcd_tens = 4'd1; bcd_hund = 4'd4; bcd_thou = 4'd1;
    neg = 1'b0; over_range = 1'b0;
    repeat (5) @(negedge clk);
    capture(6, 0, 2, 1, 1'b0, 1'b0);
    @(negedge clk);
    bcd_units = 4'd13; neg = 1'b1; over_range = 1'b1;
    repeat (3) @(negedge clk);

    cur_req = "R8";
    capture(7, 4, 1, 0, 1'b1, 1'b1);
    @(negedge clk);
    lamp_test = 1'b1; bcd_units = 4'd2; over_range = 1'b0;
    repeat (3) @(negedge clk);
    capture(3, 3, 3, 0, 1'b0, 1'b0);
    lamp_test = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b0; lamp_test = 1'b1;
    repeat (2) @(negedge clk);
    lamp_test = 1'b0;
    cur_req = "R1";
    repeat (2) @(negedge clk);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule